// File: doc/BRIEF.md
# Video Processor CPU Register Interface

This block is the register front end that a host CPU uses to reach a tile-based video processor. The CPU performs single-cycle accesses to eight byte-wide registers chosen by a 3-bit offset. Through them it sets control and mask bytes, polls a status byte whose vertical-blank flag is raised by an external pulse, loads sprite attribute memory through an address/data pair, and sets up scroll and video-memory addresses through two registers that share a first/second write toggle.

A data port with a one-byte read-ahead buffer reaches video memory. Pattern and nametable locations go out on an external request port. The 32-entry colour palette is held inside the block. Palette reads skip the read-ahead delay. Mirrored palette entries are folded onto their base entry. Bits that no register drives come from the last byte written, which models a floating bus.

Top module: `vidreg_cpu_if`

## Requirements
- R1: A write to offset 2 (status) leaves the status register unchanged. It still updates the floating-bus byte.
- R2: A write to offset 0 stores the byte on ctrl_o and copies bits [1:0] of the byte into bits [11:10] of the 15-bit temporary address.
- R3: Offset 5 with the toggle clear: fine X takes data[2:0], temp[4:0] takes data[7:3], and the toggle is set. With the toggle set: temp[14:12] takes data[2:0], temp[9:5] takes data[7:3], and the toggle is cleared.
- R4: Offset 6 with the toggle clear: temp[13:8] takes data[5:0], temp[14] is cleared, and the toggle is set. With the toggle set: temp[7:0] takes the byte, the whole temp value is copied into the VRAM address, and the toggle is cleared.
- R5: A read of offset 2 returns {vblank, 2'b00, floating[4:0]}. It then clears the vblank flag (status bit 7) and the toggle. A vblank_set pulse sets the flag, and it wins over a clear in the same cycle.
- R6: Each access to offset 7 advances the VRAM address by 32 when ctrl bit 2 is 1, and by 1 otherwise. The address wraps modulo 2^15. It resets to 0.
- R7: A read of offset 7 at an address whose bits [13:8] are not 0x3F returns the previous buffer content. The buffer is then reloaded from external memory. The external port takes the request in one cycle and returns data in the next cycle.
- R8: A read of offset 7 at an address whose bits [13:8] are 0x3F reloads the buffer from the external address (address[13:0] − 0x1000).
- R9: Palette index = address[4:0]. A write clears index bit 4 when index bits [1:0] are 00. A read clears it when (index & 0x13) = 0x10. A read returns {floating[7:6], entry[5:0]} at once, and only 6 bits are stored.
- R10: Every register write sets the floating-bus byte to the written value. Reads of offsets 0, 1, 3, 5 and 6 return that byte.
- R11: A write to offset 4 stores the byte at the attribute address and then increments that address (8-bit wrap). A read of offset 4 returns the entry and leaves the address unchanged. Offset 3 sets the address.
- R12: A data write at a non-palette address goes out as an external write request. A palette write never reaches the external port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_ofs | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read result, registered, valid from the cycle after a read |
| vblank_set | input | 1 | Pulse that sets the vertical-blank flag |
| status_o | output | 8 | Status register |
| ctrl_o | output | 8 | Control register |
| mask_o | output | 8 | Mask register |
| fine_x_o | output | 3 | Fine horizontal scroll |
| taddr_o | output | 15 | Temporary address |
| vaddr_o | output | 15 | Current VRAM address |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | External request is a write |
| mem_addr | output | 14 | External address |
| mem_wdata | output | 8 | External write byte |
| mem_rdata | input | 8 | External read byte, valid the cycle after a read request |

## Verification
The bench builds the block with its default parameters: 15-bit video addresses, a 256-entry attribute memory and a 32-entry palette of 6-bit entries. With these, a short sequence of writes can drive the address to 0x7FFF and show that it wraps to zero. The same setup reaches palette indices 0x10 and 0x14, where folding applies, and the 0x3Fxx to 0x2Fxx buffer fill. Stepping the attribute address by one shows that writes advance it and reads do not.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;
  localparam int VA_W   = 15;  // video address width
  localparam int MEM_AW = 14;  // external address width
  localparam int PAL_AW = 5;   // palette index width
  localparam int PAL_DW = 6;   // palette entry width
  localparam int OAM_AW = 8;   // attribute memory address width
  localparam int INC_BIT = 2;  // ctrl bit selecting the +32 step
  localparam logic [5:0] PAL_PAGE = 6'h3F;
  localparam logic [MEM_AW-1:0] PAL_SHADOW = 14'h1000;

  typedef enum logic [2:0] {
    OFS_CTRL = 3'd0,
    OFS_MASK = 3'd1,
    OFS_STAT = 3'd2,
    OFS_OADR = 3'd3,
    OFS_ODAT = 3'd4,
    OFS_SCRL = 3'd5,
    OFS_ADDR = 3'd6,
    OFS_DATA = 3'd7
  } reg_ofs_e;
endpackage

// File: rtl/vidreg_scroll.sv
module vidreg_scroll
  import vidreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_scrl,
  input  logic            wr_addr,
  input  logic            data_step,
  input  logic            step32,
  input  logic            tog_clr,
  input  logic [7:0]      wdata,
  output logic [VA_W-1:0] taddr,
  output logic [VA_W-1:0] vaddr,
  output logic [2:0]      fine_x,
  output logic            toggle
);
  logic [VA_W-1:0] t_n, v_n, step;
  logic [2:0]      f_n;
  logic            g_n, upd;

  assign step = step32 ? VA_W'(32) : VA_W'(1);
  assign upd  = wr_ctrl | wr_scrl | wr_addr | data_step | tog_clr;

  always_comb begin
    t_n = taddr;
    v_n = vaddr;
    f_n = fine_x;
    g_n = toggle;
    if (wr_ctrl) t_n[11:10] = wdata[1:0];
    if (wr_scrl) begin
      if (!toggle) begin
        f_n       = wdata[2:0];
        t_n[4:0]  = wdata[7:3];
        g_n       = 1'b1;
      end else begin
        t_n[14:12] = wdata[2:0];
        t_n[9:5]   = wdata[7:3];
        g_n        = 1'b0;
      end
    end
    if (wr_addr) begin
      if (!toggle) begin
        t_n[13:8] = wdata[5:0];
        t_n[14]   = 1'b0;
        g_n       = 1'b1;
      end else begin
        t_n[7:0] = wdata;
        v_n      = t_n;
        g_n      = 1'b0;
      end
    end
    if (data_step) v_n = vaddr + step;
    if (tog_clr)   g_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taddr  <= '0;
      vaddr  <= '0;
      fine_x <= '0;
      toggle <= 1'b0;
    end else if (upd) begin
      taddr  <= t_n;
      vaddr  <= v_n;
      fine_x <= f_n;
      toggle <= g_n;
    end
  end

  // R6: data access steps the address by the selected amount
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_step |=> vaddr == $past(vaddr) + $past(step));
  // R5: status read leaves the toggle clear
  p_tog_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tog_clr |=> !toggle);
  // R2: control write lands in temp[11:10]
  p_ctrl_nt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> taddr[11:10] == $past(wdata[1:0]));
  // R4: second address write makes both addresses equal
  p_addr_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && toggle) |=> (vaddr == taddr) && !toggle);
endmodule

// File: rtl/vidreg_oam.sv
module vidreg_oam #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_adr,
  input  logic          wr_dat,
  input  logic          rd_dat,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr, ptr_n;

  always_comb begin
    ptr_n = ptr;
    if (wr_adr)      ptr_n = wdata[AW-1:0];
    else if (wr_dat) ptr_n = ptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr <= '0;
    else if (wr_adr || wr_dat) ptr <= ptr_n;
  end

  always_ff @(posedge clk) begin
    if (wr_dat) mem[ptr] <= wdata;
  end

  assign rdata = mem[ptr];

  // R11: reads never move the attribute pointer
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat |=> ptr == $past(ptr));
  // R11: data writes post-increment the pointer
  p_wr_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> ptr == $past(ptr) + AW'(1));
endmodule

// File: rtl/vidreg_pal.sv
module vidreg_pal #(
  parameter int AW = 5,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wi, ri;

  always_comb begin
    wi = widx;
    if (widx[1:0] == 2'b00) wi[AW-1] = 1'b0;
    ri = ridx;
    if (ridx[AW-1] && ridx[1:0] == 2'b00) ri[AW-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wi] <= wdata;
  end

  assign rdata = mem[ri];
endmodule

// File: rtl/vidreg_cpu_if.sv
module vidreg_cpu_if
  import vidreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_ofs,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              vblank_set,
  output logic [7:0]        status_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        mask_o,
  output logic [2:0]        fine_x_o,
  output logic [VA_W-1:0]   taddr_o,
  output logic [VA_W-1:0]   vaddr_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  reg_ofs_e ofs;
  logic wr, rd, stat_rd, data_acc, in_pal, toggle;
  logic [7:0] ob_q, rbuf_q, rd_mux, buf_eff, oam_rd;
  logic [PAL_DW-1:0] pal_rd;
  logic vbl_q, vbl_n, load_q;

  assign ofs      = reg_ofs_e'(cpu_ofs);
  assign wr       = cpu_sel & cpu_we;
  assign rd       = cpu_sel & ~cpu_we;
  assign stat_rd  = rd && ofs == OFS_STAT;
  assign data_acc = cpu_sel && ofs == OFS_DATA;
  assign in_pal   = vaddr_o[13:8] == PAL_PAGE;

  vidreg_scroll u_scroll (
    .clk(clk), .rst_n(srst_n),
    .wr_ctrl(wr && ofs == OFS_CTRL), .wr_scrl(wr && ofs == OFS_SCRL),
    .wr_addr(wr && ofs == OFS_ADDR), .data_step(data_acc),
    .step32(ctrl_o[INC_BIT]), .tog_clr(stat_rd), .wdata(cpu_wdata),
    .taddr(taddr_o), .vaddr(vaddr_o), .fine_x(fine_x_o), .toggle(toggle)
  );

  vidreg_oam #(.AW(OAM_AW)) u_oam (
    .clk(clk), .rst_n(srst_n),
    .wr_adr(wr && ofs == OFS_OADR), .wr_dat(wr && ofs == OFS_ODAT),
    .rd_dat(rd && ofs == OFS_ODAT), .wdata(cpu_wdata), .rdata(oam_rd)
  );

  vidreg_pal #(.AW(PAL_AW), .DW(PAL_DW)) u_pal (
    .clk(clk), .we(wr && ofs == OFS_DATA && in_pal),
    .widx(vaddr_o[PAL_AW-1:0]), .wdata(cpu_wdata[PAL_DW-1:0]),
    .ridx(vaddr_o[PAL_AW-1:0]), .rdata(pal_rd)
  );

  // external port: every data access except palette writes
  assign mem_req   = data_acc && !(cpu_we && in_pal);
  assign mem_we    = cpu_we;
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = (!cpu_we && in_pal) ? vaddr_o[MEM_AW-1:0] - PAL_SHADOW
                                         : vaddr_o[MEM_AW-1:0];

  // a reload still in flight is forwarded straight from the port
  assign buf_eff = load_q ? mem_rdata : rbuf_q;

  always_comb begin
    vbl_n = vbl_q;
    if (stat_rd)    vbl_n = 1'b0;
    if (vblank_set) vbl_n = 1'b1;
    case (ofs)
      OFS_STAT: rd_mux = {vbl_q, 2'b00, ob_q[4:0]};
      OFS_ODAT: rd_mux = oam_rd;
      OFS_DATA: rd_mux = in_pal ? {ob_q[7:6], pal_rd} : buf_eff;
      default:  rd_mux = ob_q;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_o    <= '0;
      mask_o    <= '0;
      ob_q      <= '0;
      vbl_q     <= 1'b0;
      rbuf_q    <= '0;
      load_q    <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (wr && ofs == OFS_CTRL) ctrl_o <= cpu_wdata;
      if (wr && ofs == OFS_MASK) mask_o <= cpu_wdata;
      if (wr)                    ob_q   <= cpu_wdata;
      if (stat_rd || vblank_set) vbl_q  <= vbl_n;
      if (load_q)                rbuf_q <= mem_rdata;
      load_q <= rd && ofs == OFS_DATA;
      if (rd)                    cpu_rdata <= rd_mux;
    end
  end

  assign status_o = {vbl_q, 7'b0};

  // R5: set pulse always leaves the flag raised
  p_vbl_set_r5: assert property (@(posedge clk) disable iff (!srst_n)
    vblank_set |=> status_o[7]);
  // R5: status read without a set clears the flag
  p_vbl_clr_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (stat_rd && !vblank_set) |=> !status_o[7]);
  // R1: writes to offset 2 do not touch status
  p_stat_ro_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (wr && ofs == OFS_STAT && !vblank_set) |=> $stable(status_o));
  // R10: floating-bus byte follows every write
  p_ob_track_r10: assert property (@(posedge clk) disable iff (!srst_n)
    wr |=> ob_q == $past(cpu_wdata));
  // R12: palette page never written externally
  p_pal_local_r12: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_req && mem_we) |-> mem_addr[13:8] != PAL_PAGE);
endmodule

// File: tb/tb_vidreg_cpu_if.sv
module tb_vidreg_cpu_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 1'b0, cpu_we = 1'b0, vblank_set = 1'b0;
  logic [2:0] cpu_ofs = 3'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata, status_o, ctrl_o, mask_o, mem_wdata;
  logic [2:0] fine_x_o;
  logic [14:0] taddr_o, vaddr_o;
  logic mem_req, mem_we;
  logic [13:0] mem_addr;
  logic [7:0] mrd;

  int checks = 0;
  int errors = 0;
  int pal_ext_wr = 0;

  always #10 clk = ~clk;  // 50 MHz

  vidreg_cpu_if dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_ofs(cpu_ofs), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .vblank_set(vblank_set), .status_o(status_o), .ctrl_o(ctrl_o),
    .mask_o(mask_o), .fine_x_o(fine_x_o), .taddr_o(taddr_o),
    .vaddr_o(vaddr_o), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mrd)
  );

  // external memory model: one-cycle read latency
  logic [7:0] vmem [4096];
  function automatic int midx(input logic [13:0] a);
    return int'({a[13:12], a[9:0]});
  endfunction
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) vmem[midx(mem_addr)] <= mem_wdata;
      else        mrd <= vmem[midx(mem_addr)];
      if (mem_we && mem_addr[13:8] == 6'h3F) pal_ext_wr <= pal_ext_wr + 1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_ofs = o; cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] o, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_ofs = o;
    @(posedge clk);
    @(negedge clk);
    cpu_sel = 1'b0;
    d = cpu_rdata;
  endtask

  typedef struct packed {
    logic       we;
    logic [2:0] ofs;
    logic [7:0] dat;
    logic       ck;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 8'h03, 1'b0, 8'h00, 4'd2},   // R2 ctrl, +1 step
    '{1'b1, 3'd6, 8'h21, 1'b0, 8'h00, 4'd4},   // R4
    '{1'b1, 3'd6, 8'h08, 1'b0, 8'h00, 4'd4},   // R4 vaddr 2108
    '{1'b1, 3'd7, 8'hAA, 1'b0, 8'h00, 4'd12},  // R12 external write
    '{1'b1, 3'd7, 8'hBB, 1'b0, 8'h00, 4'd12},  // R12
    '{1'b1, 3'd6, 8'h21, 1'b0, 8'h00, 4'd4},
    '{1'b1, 3'd6, 8'h08, 1'b0, 8'h00, 4'd4},
    '{1'b0, 3'd7, 8'h00, 1'b1, 8'h00, 4'd7},   // R7 stale buffer
    '{1'b0, 3'd7, 8'h00, 1'b1, 8'hAA, 4'd7},   // R7
    '{1'b0, 3'd7, 8'h00, 1'b1, 8'hBB, 4'd7},   // R7
    '{1'b1, 3'd6, 8'h3F, 1'b0, 8'h00, 4'd9},
    '{1'b1, 3'd6, 8'h00, 1'b0, 8'h00, 4'd9},
    '{1'b1, 3'd7, 8'h15, 1'b0, 8'h00, 4'd9},   // R9 pal[0]
    '{1'b1, 3'd7, 8'hC7, 1'b0, 8'h00, 4'd9},   // R9 pal[1] keeps 6 bits
    '{1'b1, 3'd6, 8'h3F, 1'b0, 8'h00, 4'd9},
    '{1'b1, 3'd6, 8'h10, 1'b0, 8'h00, 4'd9},
    '{1'b0, 3'd7, 8'h00, 1'b1, 8'h15, 4'd9},   // R9 read fold 0x10 -> 0
    '{1'b1, 3'd6, 8'h3F, 1'b0, 8'h00, 4'd9},
    '{1'b1, 3'd6, 8'h01, 1'b0, 8'h00, 4'd9},
    '{1'b1, 3'd1, 8'hC0, 1'b0, 8'h00, 4'd10},  // R10 floating = C0
    '{1'b0, 3'd7, 8'h00, 1'b1, 8'hC7, 4'd9},   // R9 top bits from bus
    '{1'b1, 3'd6, 8'h3F, 1'b0, 8'h00, 4'd9},
    '{1'b1, 3'd6, 8'h14, 1'b0, 8'h00, 4'd9},
    '{1'b1, 3'd7, 8'h2A, 1'b0, 8'h00, 4'd9},   // R9 write fold 0x14 -> 4
    '{1'b1, 3'd6, 8'h3F, 1'b0, 8'h00, 4'd9},
    '{1'b1, 3'd6, 8'h04, 1'b0, 8'h00, 4'd9},
    '{1'b0, 3'd7, 8'h00, 1'b1, 8'h2A, 4'd9},   // R9
    '{1'b1, 3'd6, 8'h2F, 1'b0, 8'h00, 4'd8},
    '{1'b1, 3'd6, 8'h05, 1'b0, 8'h00, 4'd8},
    '{1'b1, 3'd7, 8'h5C, 1'b0, 8'h00, 4'd8},   // R8 mem[2F05]
    '{1'b1, 3'd6, 8'h3F, 1'b0, 8'h00, 4'd8},
    '{1'b1, 3'd6, 8'h05, 1'b0, 8'h00, 4'd8},
    '{1'b0, 3'd7, 8'h00, 1'b0, 8'h00, 4'd8},   // R8 palette read fills buffer
    '{1'b1, 3'd6, 8'h20, 1'b0, 8'h00, 4'd8},
    '{1'b1, 3'd6, 8'h00, 1'b0, 8'h00, 4'd8},
    '{1'b0, 3'd7, 8'h00, 1'b1, 8'h5C, 4'd8},   // R8
    '{1'b1, 3'd3, 8'h10, 1'b0, 8'h00, 4'd11},  // R11
    '{1'b1, 3'd4, 8'h11, 1'b0, 8'h00, 4'd11},
    '{1'b1, 3'd4, 8'h22, 1'b0, 8'h00, 4'd11},
    '{1'b1, 3'd3, 8'h10, 1'b0, 8'h00, 4'd11},
    '{1'b0, 3'd4, 8'h00, 1'b1, 8'h11, 4'd11},  // R11
    '{1'b0, 3'd4, 8'h00, 1'b1, 8'h11, 4'd11},  // R11 no increment
    '{1'b1, 3'd3, 8'h11, 1'b0, 8'h00, 4'd11},
    '{1'b0, 3'd4, 8'h00, 1'b1, 8'h22, 4'd11},  // R11
    '{1'b1, 3'd2, 8'hFF, 1'b0, 8'h00, 4'd1},   // R1 write to status
    '{1'b0, 3'd2, 8'h00, 1'b1, 8'h1F, 4'd5},   // R5 {0,00,1F}
    '{1'b0, 3'd0, 8'h00, 1'b1, 8'hFF, 4'd10},  // R10
    '{1'b0, 3'd5, 8'h00, 1'b1, 8'hFF, 4'd10}   // R10
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    chk("R5 reset status", {8'h0, status_o}, 16'h0000);
    chk("R6 reset vaddr", {1'b0, vaddr_o}, 16'h0000);
    chk("R4 reset temp", {1'b0, taddr_o}, 16'h0000);
    chk("R7 reset rdata", {8'h0, cpu_rdata}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wreg(VECS[i].ofs, VECS[i].dat);
      else begin
        rreg(VECS[i].ofs, r);
        if (VECS[i].ck) begin
          checks++;
          if (r !== VECS[i].exp) begin
            errors++;
            $display("FAIL R%0d vector %0d: actual %h expected %h",
                     VECS[i].req, i, r, VECS[i].exp);
          end
        end
      end
    end
    chk("R12 external byte", {8'h0, vmem[midx(14'h2108)]}, 16'h00AA);

    // R2 control write
    wreg(3'd0, 8'h02);
    chk("R2 ctrl", {8'h0, ctrl_o}, 16'h0002);
    chk("R2 temp[11:10]", {14'h0, taddr_o[11:10]}, 16'h0002);

    // R1: status write ignored while flag set
    @(negedge clk); vblank_set = 1'b1; @(negedge clk); vblank_set = 1'b0;
    wreg(3'd2, 8'h00);
    chk("R1 status kept", {8'h0, status_o}, 16'h0080);
    rreg(3'd1, r);
    chk("R10 bus after status write", {8'h0, r}, 16'h0000);

    // R5: read returns and clears the flag
    rreg(3'd2, r);
    chk("R5 read value", {8'h0, r}, 16'h0080);
    chk("R5 flag cleared", {8'h0, status_o}, 16'h0000);
    // R5: set in the same cycle as a read wins
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_ofs = 3'd2; vblank_set = 1'b1;
    @(negedge clk);
    cpu_sel = 1'b0; vblank_set = 1'b0;
    chk("R5 set wins", {8'h0, status_o}, 16'h0080);
    chk("R5 old flag returned", {8'h0, cpu_rdata}, 16'h0000);

    // R5: status read resets the toggle
    wreg(3'd6, 8'h22);
    rreg(3'd2, r);
    wreg(3'd6, 8'h23);
    wreg(3'd6, 8'h45);
    chk("R5/R4 toggle reset", {1'b0, vaddr_o}, 16'h2345);

    // R3 scroll pair
    wreg(3'd5, 8'h7D);
    chk("R3 fine x", {13'h0, fine_x_o}, 16'h0005);
    chk("R3 temp[4:0]", {11'h0, taddr_o[4:0]}, 16'h000F);
    wreg(3'd5, 8'h5E);
    chk("R3 temp[14:12]", {13'h0, taddr_o[14:12]}, 16'h0006);
    chk("R3 temp[9:5]", {11'h0, taddr_o[9:5]}, 16'h000B);
    // R4 first write clears bit 14
    wreg(3'd6, 8'h3F);
    chk("R4 temp[14:8]", {9'h0, taddr_o[14:8]}, 16'h003F);
    wreg(3'd6, 8'h80);
    chk("R4 copy", {1'b0, vaddr_o}, 16'h3F80);

    // R6 +32 step
    wreg(3'd0, 8'h04);
    wreg(3'd6, 8'h20);
    wreg(3'd6, 8'h00);
    wreg(3'd7, 8'h33);
    chk("R6 step 32 write", {1'b0, vaddr_o}, 16'h2020);
    chk("R12 external write", {8'h0, vmem[midx(14'h2000)]}, 16'h0033);
    rreg(3'd7, r);
    chk("R6 step 32 read", {1'b0, vaddr_o}, 16'h2040);

    // R6 wrap from 7FFF
    wreg(3'd0, 8'h00);
    wreg(3'd6, 8'h3F);
    wreg(3'd5, 8'hFF);
    wreg(3'd5, 8'hFF);
    wreg(3'd6, 8'hFF);
    chk("R6 max address", {1'b0, vaddr_o}, 16'h7FFF);
    wreg(3'd7, 8'h01);
    chk("R6 wrap", {1'b0, vaddr_o}, 16'h0000);
    chk("R12 palette stays local", 16'(pal_ext_wr), 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule